// File: doc/BRIEF.md
# Dirty-Line Read Response Controller

This block is the tag-and-state keeper of a small lower-level data cache. It sits between an upper-level data cache and a memory write port. The upper cache sends two kinds of request through one valid/ready request channel: line writebacks and reads that do not snoop. Each writeback carries a flag that marks the line as modified upstream. Each read carries a shareable attribute.

The lines are held in a direct-mapped array. Each entry has a state (invalid, clean or dirty), a tag and a small data payload. The interesting case is a read that finds its line dirty. One option is to push the line out to memory first and answer with clean data, so the local copy becomes clean. The other is to hand the modified line upward, marked dirty, and drop the local copy, which saves a memory write.

A static mode input picks which option applies to non-shareable reads. Shareable reads always take the write-to-memory route. Addresses are line addresses: the low `IDX_W` bits select the entry and the remaining upper bits form the tag.

Top module: `dirty_rsp_ctrl`

## Requirements
- R1: After reset every entry is invalid, so any read returns `rsp_hit`=0. `mem_valid` and `rsp_valid` are low and `req_ready` is high.
- R2: An accepted writeback (`req_wb`=1) writes its tag and data into the entry at its index. The state becomes dirty when `req_udirty`=1 and clean when `req_udirty`=0. A writeback produces no response.
- R3: A read that hits a clean entry gives a one-cycle `rsp_valid` pulse in the second cycle after acceptance, with `rsp_hit`=1, `rsp_dirty`=0 and the stored data. It causes no memory write and no state change.
- R4: A read whose entry is invalid, or holds a different tag, returns `rsp_hit`=0 and `rsp_dirty`=0. It does not allocate, and it leaves the resident line intact.
- R5: When `cfg_fast`=0, a read that hits a dirty entry raises `mem_valid` with `mem_addr` equal to the line address and `mem_data` equal to the line data. After the handshake it answers with `rsp_hit`=1 and `rsp_dirty`=0, and the entry becomes clean.
- R6: On the write-to-memory path, `mem_valid`, `mem_addr` and `mem_data` hold steady until `mem_ready` is seen high. `rsp_valid` is asserted only in the cycle after the edge where `mem_valid` and `mem_ready` were both high.
- R7: When `cfg_fast`=1, a non-shareable read (`req_shareable`=0) that hits a dirty entry answers with `rsp_hit`=1, `rsp_dirty`=1 and the line data. It causes no memory write and leaves the entry invalid.
- R8: A read with `req_shareable`=1 never receives `rsp_dirty`=1. When it hits a dirty entry it takes the R5 path, whatever the value of `cfg_fast`.
- R9: `req_ready` is low from the cycle after an accepted request until that request has finished, including every cycle in which `mem_valid` is high.
- R10: A dirty writeback to an entry invalidated under R7 re-allocates it as dirty with the new data. A later dirty hit then exposes the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fast | input | 1 | 1 hands dirty lines upward for non-shareable reads |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_wb | input | 1 | 1 = writeback, 0 = read |
| req_addr | input | ADDR_W | Line address; low IDX_W bits are the index |
| req_data | input | DATA_W | Writeback payload |
| req_udirty | input | 1 | Writeback carries a modified line |
| req_shareable | input | 1 | Read targets a shareable region |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_hit | output | 1 | Line was present |
| rsp_dirty | output | 1 | Data is handed over as modified |
| rsp_data | output | DATA_W | Line payload (zero on a miss) |
| mem_valid | output | 1 | Memory write pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Line address being written |
| mem_data | output | DATA_W | Line payload being written |

## Verification
The hardest case to reach is a line that was handed upward under the fast mode and is then written back again. Reaching it needs a dirty install, a fast non-shareable read, a confirming miss and a second dirty writeback, all on the same entry. The directed stimulus walks through that chain in order. It then switches to the compliant mode so that the memory port shows which data now lives in the entry. The memory-stall window is driven by delaying `mem_ready` for a chosen number of cycles. This shows that the response waits for the handshake and that the write channel holds still meanwhile.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
    typedef enum logic [1:0] {
        LS_INV   = 2'd0,
        LS_CLEAN = 2'd1,
        LS_DIRTY = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_DECIDE = 2'd1,
        CS_FLUSH  = 2'd2
    } ctl_st_e;
endpackage

// File: rtl/dlr_addr_split.sv
module dlr_addr_split #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic [IDX_W-1:0]        idx,
    output logic [ADDR_W-IDX_W-1:0] tag
);
    assign idx = addr[IDX_W-1:0];
    assign tag = addr[ADDR_W-1:IDX_W];
endmodule

// File: rtl/dlr_line_array.sv
module dlr_line_array #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output dlr_pkg::line_st_e   rd_st,
    output logic [TAG_W-1:0]    rd_tag,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  dlr_pkg::line_st_e   wr_st,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [DATA_W-1:0]   wr_data
);
    localparam int NLINES = 1 << IDX_W;

    dlr_pkg::line_st_e  st_q   [NLINES];
    logic [TAG_W-1:0]   tag_q  [NLINES];
    logic [DATA_W-1:0]  data_q [NLINES];

    // State bits need reset; tag and payload are qualified by the state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i] <= dlr_pkg::LS_INV;
            end
        end else if (wr_en) begin
            st_q[wr_idx] <= wr_st;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_st   = st_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/dirty_rsp_ctrl.sv
module dirty_rsp_ctrl #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fast,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wb,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_udirty,
    input  logic              req_shareable,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_dirty,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    import dlr_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctl_st_e           st;
        logic              wb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              udirty;
        logic              shr;
        logic              rv;
        logic              rh;
        logic              rd;
        logic [DATA_W-1:0] rdata;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;

    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    line_st_e          rd_st;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    line_st_e          wr_st;
    logic [DATA_W-1:0] wr_data;
    logic              hit;

    dlr_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_split (
        .addr (r_q.addr),
        .idx  (cur_idx),
        .tag  (cur_tag)
    );

    dlr_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (cur_idx),
        .rd_st   (rd_st),
        .rd_tag  (rd_tag),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (cur_idx),
        .wr_st   (wr_st),
        .wr_tag  (cur_tag),
        .wr_data (wr_data)
    );

    assign hit = (rd_st != LS_INV) && (rd_tag == cur_tag);

    always_comb begin
        r_d     = r_q;
        r_d.rv  = 1'b0;
        wr_en   = 1'b0;
        wr_st   = LS_INV;
        wr_data = r_q.data;
        unique case (r_q.st)
            CS_IDLE: begin
                if (req_valid) begin
                    r_d.st     = CS_DECIDE;
                    r_d.wb     = req_wb;
                    r_d.addr   = req_addr;
                    r_d.data   = req_data;
                    r_d.udirty = req_udirty;
                    r_d.shr    = req_shareable;
                end
            end
            CS_DECIDE: begin
                r_d.st = CS_IDLE;
                if (r_q.wb) begin
                    wr_en = 1'b1;
                    wr_st = r_q.udirty ? LS_DIRTY : LS_CLEAN;
                end else if (!hit) begin
                    r_d.rv    = 1'b1;
                    r_d.rh    = 1'b0;
                    r_d.rd    = 1'b0;
                    r_d.rdata = '0;
                end else if (rd_st == LS_CLEAN) begin
                    r_d.rv    = 1'b1;
                    r_d.rh    = 1'b1;
                    r_d.rd    = 1'b0;
                    r_d.rdata = rd_data;
                end else if (cfg_fast && !r_q.shr) begin
                    // hand the modified line upward and drop the local copy
                    r_d.rv    = 1'b1;
                    r_d.rh    = 1'b1;
                    r_d.rd    = 1'b1;
                    r_d.rdata = rd_data;
                    wr_en     = 1'b1;
                    wr_st     = LS_INV;
                    wr_data   = rd_data;
                end else begin
                    r_d.st   = CS_FLUSH;
                    r_d.data = rd_data;
                end
            end
            CS_FLUSH: begin
                if (mem_ready) begin
                    wr_en     = 1'b1;
                    wr_st     = LS_CLEAN;
                    r_d.st    = CS_IDLE;
                    r_d.rv    = 1'b1;
                    r_d.rh    = 1'b1;
                    r_d.rd    = 1'b0;
                    r_d.rdata = r_q.data;
                end
            end
            default: r_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == CS_IDLE);
    assign mem_valid = (r_q.st == CS_FLUSH);
    assign mem_addr  = r_q.addr;
    assign mem_data  = r_q.data;
    assign rsp_valid = r_q.rv;
    assign rsp_hit   = r_q.rh;
    assign rsp_dirty = r_q.rd;
    assign rsp_data  = r_q.rdata;
endmodule

// File: rtl/dlr_checker.sv
module dlr_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_fast,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_shareable,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_dirty,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data
);
    logic shr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shr_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            shr_q <= req_shareable;
        end
    end

    a_r8_no_dirty_shareable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_dirty |-> !shr_q);

    a_r6_rsp_waits_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> !rsp_valid);

    a_r6_mem_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    a_r5_clean_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> rsp_valid && rsp_hit && !rsp_dirty && !mem_valid);

    a_r9_busy_during_flush: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r7_dirty_needs_fast: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_dirty |-> cfg_fast && rsp_hit);

    a_r4_miss_not_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> !rsp_dirty);
endmodule

bind dirty_rsp_ctrl dlr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dlr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_fast      (cfg_fast),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_shareable (req_shareable),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_dirty     (rsp_dirty),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .mem_data      (mem_data)
);

// File: tb/test_dirty_rsp_ctrl.sv
module test_dirty_rsp_ctrl;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_fast = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_wb = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_udirty = 1'b0;
    logic          req_shareable = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_dirty;
    logic [DW-1:0] rsp_data;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    int n_run  = 0;
    int n_fail = 0;

    logic          got_hit, got_dirty, got_done;
    logic [DW-1:0] got_data;
    int            mem_seen;
    logic [AW-1:0] mem_a;
    logic [DW-1:0] mem_d;
    logic          busy_err, stable_err, post_mem;

    always #2 clk = ~clk;

    dirty_rsp_ctrl #(.ADDR_W(AW), .IDX_W(3), .DATA_W(DW)) i_dirty_rsp_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast),
        .req_valid(req_valid), .req_ready(req_ready), .req_wb(req_wb),
        .req_addr(req_addr), .req_data(req_data), .req_udirty(req_udirty),
        .req_shareable(req_shareable),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty),
        .rsp_data(rsp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_wb(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ud);
        @(negedge clk);
        req_valid = 1'b1; req_wb = 1'b1; req_addr = a; req_data = d;
        req_udirty = ud; req_shareable = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; req_wb = 1'b0;
        chk(!req_ready && !rsp_valid, "R9", "writeback busy", {req_ready, rsp_valid}, 0);
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R2", "writeback done, no response",
            {req_ready, rsp_valid}, 2);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic shr, input int dly);
        @(negedge clk);
        req_valid = 1'b1; req_wb = 1'b0; req_addr = a; req_shareable = shr;
        req_data = '0; req_udirty = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 1'b0; mem_seen = 0; busy_err = 1'b0; stable_err = 1'b0;
        post_mem = 1'b0;
        for (int c = 0; c < 60 && !got_done; c++) begin
            if (rsp_valid) begin
                got_hit = rsp_hit; got_dirty = rsp_dirty; got_data = rsp_data;
                post_mem = mem_valid;
                got_done = 1'b1;
            end else begin
                if (req_ready) busy_err = 1'b1;
                if (mem_valid) begin
                    if (mem_seen == 0) begin
                        mem_a = mem_addr; mem_d = mem_data;
                    end else if (mem_addr !== mem_a || mem_data !== mem_d) begin
                        stable_err = 1'b1;
                    end
                    mem_seen++;
                    mem_ready = (mem_seen > dly);
                end else begin
                    mem_ready = 1'b0;
                end
                @(negedge clk);
            end
        end
        mem_ready = 1'b0;
        chk(got_done, "R3", "read response arrived", got_done, 1);
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(mem_valid === 1'b0 && rsp_valid === 1'b0, "R1", "mem/rsp idle after reset",
            {mem_valid, rsp_valid}, 0);
        do_read(12'h0A5, 1'b0, 0);
        chk(!got_hit && !got_dirty, "R1", "read after reset misses", {got_hit, got_dirty}, 0);
        do_read(12'h003, 1'b1, 0);
        chk(!got_hit && mem_seen == 0, "R1", "second line invalid", got_hit, 0);
    endtask

    task automatic t_clean_hit;
        do_wb(12'h0A5, 16'h1234, 1'b0);
        do_read(12'h0A5, 1'b0, 0);
        chk(got_hit && !got_dirty, "R2", "clean install hit clean", {got_hit, got_dirty}, 2);
        chk(got_data == 16'h1234 && mem_seen == 0, "R3", "clean hit data, no mem",
            got_data, 16'h1234);
        do_read(12'h0A5, 1'b0, 0);
        chk(got_hit && !got_dirty && got_data == 16'h1234, "R3", "clean hit repeatable",
            got_data, 16'h1234);
    endtask

    task automatic t_miss;
        do_read(12'h0AD, 1'b0, 0);
        chk(!got_hit && !got_dirty && mem_seen == 0, "R4", "tag conflict misses",
            {got_hit, got_dirty}, 0);
        do_read(12'h0A5, 1'b0, 0);
        chk(got_hit && got_data == 16'h1234, "R4", "miss did not allocate", got_data, 16'h1234);
    endtask

    task automatic t_compliant;
        cfg_fast = 1'b0;
        do_wb(12'h13A, 16'hBEEF, 1'b1);
        do_read(12'h13A, 1'b0, 3);
        chk(mem_seen == 4, "R6", "response waits for handshake", mem_seen, 4);
        chk(!stable_err, "R6", "mem channel stable while stalled", stable_err, 0);
        chk(mem_a == 12'h13A && mem_d == 16'hBEEF, "R5", "flush address/data",
            {mem_a, mem_d}, {12'h13A, 16'hBEEF});
        chk(got_hit && !got_dirty && got_data == 16'hBEEF, "R5", "clean response after flush",
            {got_hit, got_dirty, got_data}, {2'b10, 16'hBEEF});
        chk(!busy_err && !post_mem, "R9", "ready low during flush", busy_err, 0);
        do_read(12'h13A, 1'b0, 0);
        chk(got_hit && !got_dirty && mem_seen == 0, "R5", "line clean after flush",
            mem_seen, 0);
    endtask

    task automatic t_fast;
        @(negedge clk);
        cfg_fast = 1'b1;
        do_wb(12'h2C1, 16'hA5A5, 1'b1);
        do_read(12'h2C1, 1'b0, 0);
        chk(got_hit && got_dirty && got_data == 16'hA5A5, "R7", "dirty handed upward",
            {got_hit, got_dirty, got_data}, {2'b11, 16'hA5A5});
        chk(mem_seen == 0, "R7", "no memory write on fast path", mem_seen, 0);
        do_read(12'h2C1, 1'b0, 0);
        chk(!got_hit, "R7", "line invalid after hand-off", got_hit, 0);
    endtask

    task automatic t_fast_shareable;
        do_wb(12'h2C6, 16'h0F0F, 1'b1);
        do_read(12'h2C6, 1'b1, 1);
        chk(mem_seen == 2 && mem_d == 16'h0F0F, "R8", "shareable read flushes",
            mem_seen, 2);
        chk(got_hit && !got_dirty && got_data == 16'h0F0F, "R8", "shareable gets clean",
            {got_hit, got_dirty}, 2);
        do_read(12'h2C6, 1'b1, 0);
        chk(got_hit && !got_dirty && mem_seen == 0, "R8", "line clean after shareable flush",
            mem_seen, 0);
    endtask

    task automatic t_realloc;
        do_wb(12'h2C1, 16'h7777, 1'b1);
        @(negedge clk);
        cfg_fast = 1'b0;
        do_read(12'h2C1, 1'b0, 0);
        chk(mem_seen == 1 && mem_d == 16'h7777, "R10", "re-allocated line dirty, new data",
            mem_d, 16'h7777);
        chk(got_hit && !got_dirty && got_data == 16'h7777, "R10", "response new data",
            got_data, 16'h7777);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_hit();
        t_miss();
        t_compliant();
        t_fast();
        t_fast_shareable();
        t_realloc();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule